// File: doc/BRIEF.md
# Read-Sequence Nonvolatile Command Detector

This block sits beside the control logic of an SRAM-style memory port. It watches the stream of accesses and spots a fixed unlock run of six reads. The first five addresses of the run are always the same. The sixth address decides what is asked for: a save of the volatile array into nonvolatile storage, or a reload of the array from it. When a full run is seen, the block raises a one-cycle request pulse for the transfer engine.

Each access arrives as a single-cycle strobe. The strobe is registered from the chip-enable falling edge, so every chip-enable low pulse is one access. With the strobe come the write flag and the 13-bit address. Any write, any read that is not the next expected address, and any repeated read cancels the run. A read of the first run address always starts a new run at step one. While the transfer engine reports busy, every access is ignored and the detector stays idle. A 3-bit output shows how many run addresses have been matched so far.

Top module: `nvseq_detect`

## Requirements
- R1: After reset, progress is 0 and both request outputs are low.
- R2: Reads of 0x0000, 0x1555, 0x0AAA, 0x1FFF and 0x10F0, in that order, raise progress by one per access, from 0 to 5. The new value is visible in the cycle after the strobe.
- R3: At progress 5, a read of 0x0F0F drives store_req high for exactly one cycle, in the cycle after the strobe. Progress returns to 0 and recall_req stays low.
- R4: At progress 5, a read of 0x0F0E drives recall_req high for exactly one cycle, in the cycle after the strobe. Progress returns to 0 and store_req stays low.
- R5: A write access (acc_wr = 1) at any progress sets progress to 0 and issues no request, even when its address is the expected one.
- R6: A read of any address other than the expected next one aborts the run. Progress goes to 0 and no request is issued; this includes a wrong sixth address.
- R7: A repeated read of the address just matched counts as an intervening access and aborts the run.
- R8: A read of 0x0000 that does not complete the expected step restarts the run, so progress becomes 1.
- R9: While busy is high, accesses are ignored. Progress is 0 in the cycle after any busy cycle and no request is issued. Once busy clears, a full run is accepted again.
- R10: Cycles without a strobe leave progress unchanged and issue no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | One-cycle access strobe, one per chip-enable low pulse |
| acc_wr | input | 1 | 1 when the access is a write (write enable low) |
| acc_addr | input | 13 | Address of the access |
| busy | input | 1 | Transfer engine busy; accesses ignored while high |
| progress | output | 3 | Number of run addresses matched so far (0 to 5) |
| store_req | output | 1 | One-cycle request to save the array to nonvolatile storage |
| recall_req | output | 1 | One-cycle request to reload the array from nonvolatile storage |

## Verification
The hardest state to reach is progress 5 with a disturbance on the sixth access. Uniform random addresses almost never walk the five-step prefix, so the stimulus biases every access toward the next expected address. It then mixes in writes, the first run address, repeats of the last address and busy cycles at a low rate. Directed runs also cover a write of a valid key at step five, a wrong sixth address, and a restart through 0x0000 in the middle of a run.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;
    localparam int ADDR_W     = 13;
    localparam int PREFIX_LEN = 5;
    localparam int STEP_W     = $clog2(PREFIX_LEN + 1);

    localparam logic [12:0] STORE_KEY  = 13'h0F0F;
    localparam logic [12:0] RECALL_KEY = 13'h0F0E;

    // Ordered prefix of the unlock run; order is behaviour.
    function automatic logic [12:0] prefix_key(input int idx);
        case (idx)
            0:       return 13'h0000;
            1:       return 13'h1555;
            2:       return 13'h0AAA;
            3:       return 13'h1FFF;
            default: return 13'h10F0;
        endcase
    endfunction

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic              store;
        logic              recall;
    } nvseq_state_t;
endpackage

// File: rtl/nvseq_keymatch.sv
module nvseq_keymatch
    import nvseq_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int NPF = PREFIX_LEN
) (
    input  logic [AW-1:0]  addr,
    output logic [NPF-1:0] prefix_hit,
    output logic           store_hit,
    output logic           recall_hit
);
    for (genvar g = 0; g < NPF; g++) begin : g_prefix
        assign prefix_hit[g] = (addr == AW'(prefix_key(g)));
    end

    assign store_hit  = (addr == AW'(STORE_KEY));
    assign recall_hit = (addr == AW'(RECALL_KEY));
endmodule

// File: rtl/nvseq_tracker.sv
module nvseq_tracker
    import nvseq_pkg::*;
#(
    parameter int NPF = PREFIX_LEN,
    parameter int SW  = STEP_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           acc_vld,
    input  logic           acc_wr,
    input  logic           busy,
    input  logic [NPF-1:0] prefix_hit,
    input  logic           store_hit,
    input  logic           recall_hit,
    output logic [SW-1:0]  step,
    output logic           store_req,
    output logic           recall_req
);
    localparam logic [SW-1:0] LAST = SW'(NPF);

    typedef struct packed {
        logic [SW-1:0] step;
        logic          store;
        logic          recall;
    } trk_t;

    trk_t cur_q, nxt_d;
    logic exp_hit_d;
    logic [SW-1:0] restart_d;

    always_comb begin
        exp_hit_d = 1'b0;
        for (int i = 0; i < NPF; i++) begin
            if (cur_q.step == SW'(i)) exp_hit_d = prefix_hit[i];
        end
        restart_d = prefix_hit[0] ? SW'(1) : '0;

        nxt_d        = cur_q;
        nxt_d.store  = 1'b0;
        nxt_d.recall = 1'b0;
        if (busy) begin
            nxt_d.step = '0;
        end else if (acc_vld) begin
            if (acc_wr) begin
                nxt_d.step = '0;
            end else if (cur_q.step == LAST) begin
                nxt_d.step   = (store_hit || recall_hit) ? '0 : restart_d;
                nxt_d.store  = store_hit;
                nxt_d.recall = recall_hit;
            end else if (exp_hit_d) begin
                nxt_d.step = cur_q.step + SW'(1);
            end else begin
                nxt_d.step = restart_d;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign step       = cur_q.step;
    assign store_req  = cur_q.store;
    assign recall_req = cur_q.recall;

    a_r3_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_req && recall_req));
    a_r3_store_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        acc_vld && !busy && !acc_wr && step == LAST && store_hit |=> store_req && step == '0);
    a_r4_recall_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        acc_vld && !busy && !acc_wr && step == LAST && recall_hit |=> recall_req && step == '0);
    a_r5_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        acc_vld && acc_wr && !busy |=> step == '0 && !store_req && !recall_req);
    a_r9_busy_idle: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> step == '0 && !store_req && !recall_req);
    a_r10_hold_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_vld && !busy |=> $stable(step) && !store_req && !recall_req);
    a_r2_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        step <= LAST);
endmodule

// File: rtl/nvseq_detect.sv
module nvseq_detect
    import nvseq_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int NPF = PREFIX_LEN,
    localparam int SW = $clog2(NPF + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_vld,
    input  logic          acc_wr,
    input  logic [AW-1:0] acc_addr,
    input  logic          busy,
    output logic [SW-1:0] progress,
    output logic          store_req,
    output logic          recall_req
);
    logic [NPF-1:0] prefix_hit;
    logic           store_hit;
    logic           recall_hit;

    nvseq_keymatch #(.AW(AW), .NPF(NPF)) i_match (
        .addr       (acc_addr),
        .prefix_hit (prefix_hit),
        .store_hit  (store_hit),
        .recall_hit (recall_hit)
    );

    nvseq_tracker #(.NPF(NPF), .SW(SW)) i_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_vld    (acc_vld),
        .acc_wr     (acc_wr),
        .busy       (busy),
        .prefix_hit (prefix_hit),
        .store_hit  (store_hit),
        .recall_hit (recall_hit),
        .step       (progress),
        .store_req  (store_req),
        .recall_req (recall_req)
    );

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> progress == '0 && !store_req && !recall_req);
endmodule

// File: tb/test_nvseq_detect.sv
module test_nvseq_detect;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_vld = 1'b0;
    logic        acc_wr = 1'b0;
    logic [12:0] acc_addr = '0;
    logic        busy = 1'b0;
    logic [2:0]  progress;
    logic        store_req, recall_req;

    int checks = 0;
    int fails = 0;
    int mdl = 0;
    logic [12:0] last_addr = '0;

    always #5 clk = ~clk;

    nvseq_detect i_nvseq_detect (
        .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .busy(busy), .progress(progress),
        .store_req(store_req), .recall_req(recall_req)
    );

    function automatic logic [12:0] key(input int i);
        case (i)
            0: return 13'h0000;
            1: return 13'h1555;
            2: return 13'h0AAA;
            3: return 13'h1FFF;
            default: return 13'h10F0;
        endcase
    endfunction

    // Expected next progress and requests from the requirements.
    function automatic int exp_next(input int s, input bit wr, input logic [12:0] a,
                                    input bit bsy, output bit st, output bit rc);
        st = 0; rc = 0;
        if (bsy || wr) return 0;
        if (s == 5) begin
            if (a == 13'h0F0F) begin st = 1; return 0; end
            if (a == 13'h0F0E) begin rc = 1; return 0; end
            return (a == 13'h0000) ? 1 : 0;
        end
        if (a == key(s)) return s + 1;
        return (a == 13'h0000) ? 1 : 0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [12:0] a, input bit bsy, input string req);
        bit st, rc;
        int nx;
        nx = exp_next(mdl, wr, a, bsy, st, rc);
        acc_vld = 1'b1; acc_wr = wr; acc_addr = a; busy = bsy;
        @(negedge clk);
        acc_vld = 1'b0; acc_wr = 1'b0; busy = 1'b0;
        mdl = nx; last_addr = a;
        check(progress == 3'(nx), {req, " progress"}, progress, nx);
        check(store_req == st, {req, " store_req"}, store_req, st);
        check(recall_req == rc, {req, " recall_req"}, recall_req, rc);
    endtask

    task automatic idle(input string req);
        @(negedge clk);
        check(progress == 3'(mdl), {req, " progress hold"}, progress, mdl);
        check(!store_req && !recall_req, {req, " no pulse"}, {store_req, recall_req}, 0);
    endtask

    task automatic prefix(input int n, input string req);
        for (int i = 0; i < n; i++) access(0, key(i), 0, req);
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                fails++;
                $display("FAIL watchdog actual=timeout expected=done");
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(progress == 0, "R1 reset progress", progress, 0);
        check(!store_req && !recall_req, "R1 reset pulses", {store_req, recall_req}, 0);

        prefix(5, "R2 prefix");
        access(0, 13'h0F0F, 0, "R3 store");
        idle("R3 pulse width");
        prefix(5, "R2 prefix");
        idle("R10 gap");
        idle("R10 gap");
        access(0, 13'h0F0E, 0, "R4 recall");
        idle("R4 pulse width");

        prefix(5, "R5 setup");
        access(1, 13'h0F0F, 0, "R5 write of store key");
        prefix(2, "R5 setup");
        access(1, key(2), 0, "R5 write of expected key");

        prefix(5, "R6 setup");
        access(0, 13'h0F0D, 0, "R6 wrong sixth");
        prefix(3, "R6 setup");
        access(0, 13'h1234, 0, "R6 wrong address");

        prefix(3, "R7 setup");
        access(0, key(2), 0, "R7 repeated read");
        access(0, key(0), 0, "R7 first key");
        access(0, key(0), 0, "R7 repeat of first key");

        prefix(4, "R8 setup");
        access(0, 13'h0000, 0, "R8 restart");
        prefix(5, "R8 resume");
        access(0, 13'h0000, 0, "R8 restart at last step");

        prefix(3, "R9 setup");
        access(0, key(3), 1, "R9 busy ignores");
        for (int i = 0; i < 5; i++) access(0, key(i), 1, "R9 busy prefix");
        access(0, 13'h0F0F, 1, "R9 busy store key");
        prefix(5, "R9 after busy");
        access(0, 13'h0F0F, 0, "R9 store after busy");

        void'($urandom(32'd1234));
        for (int n = 0; n < 4000; n++) begin
            int r;
            logic [12:0] a;
            bit wr, bsy;
            r = int'($urandom_range(0, 99));
            wr = ($urandom_range(0, 19) == 0);
            bsy = ($urandom_range(0, 29) == 0);
            if (r < 70)      a = (mdl == 5) ? (($urandom_range(0, 1) == 0) ? 13'h0F0F : 13'h0F0E) : key(mdl);
            else if (r < 80) a = 13'h0000;
            else if (r < 88) a = last_addr;
            else             a = 13'($urandom);
            if ($urandom_range(0, 3) == 0) idle("R10 random gap");
            access(wr, a, bsy, "R10 random mix");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule